// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

The block gathers an outgoing Ethernet frame from 32-bit words that software writes, one at a time, to a transmit data port. The first word of a frame is a header word. Its low half gives the payload length, which excludes the 14-byte Ethernet header. Its upper half holds the first two frame bytes. Each later word adds four bytes. The block stores the bytes in a byte-lane buffer that maps onto block RAM. When enough bytes have arrived, it streams the frame out as bytes over a valid/ready/last handshake.

Two configuration inputs shape the frame. When automatic checksum insertion is off, the writer must also supply a four-byte checksum slot, and the block cuts that slot from the transmitted frame. When padding is on, any frame shorter than the Ethernet minimum is filled with zero bytes up to 60 bytes. A one-cycle completion pulse marks each frame that has been fully sent. A one-cycle error pulse marks a header with an illegal length. An abort input drops whatever frame is in progress.

While a frame is streaming out, the block raises a busy flag. The writer must hold any pending word until busy clears, so no word is lost.

Top module: `txf_assembler`

## Requirements
- R1: In the idle state, an accepted write is a header word. Bits 15:0 are the payload length, bits 23:16 become frame byte 0 and bits 31:24 become frame byte 1.
- R2: A header length above 2032 is rejected. evt_tx_err pulses high for exactly one cycle, in the cycle after the write. The block stays idle, no byte is captured and no output appears. The next accepted write is again treated as a header.
- R3: The expected stored byte count is the length plus 14, plus a further 4 when cfg_crc_auto is 0. cfg_crc_auto is sampled with the header word.
- R4: Each accepted write after the header appends four frame bytes, taking bits 7:0 first and bits 31:24 last.
- R5: The frame is complete on the write that brings the stored count to or beyond the expected count. The first byte is offered in the next cycle. The transmitted length is the expected count, minus 4 when cfg_crc_auto was 0. Stored bytes past that length are never sent.
- R6: When cfg_pad_en is 1 at completion and the transmitted length is below 60, zero bytes follow the frame data and exactly 60 bytes are sent.
- R7: After the byte flagged m_last is accepted, evt_tx_empty pulses high for exactly one cycle, in the next cycle. The block is then idle.
- R8: wr_busy is 1 exactly while a frame is being offered on the output. A write presented while wr_busy is 1 is not consumed. It is taken once wr_busy falls, so no word is lost.
- R9: A high abort forces idle on the next cycle. The partial or streaming frame is dropped, m_valid and wr_busy become 0, and no completion pulse follows.
- R10: While m_valid is 1 and m_ready is 0, m_valid stays 1 and m_data, m_last hold their values.
- R11: During and directly after reset, m_valid, wr_busy, evt_tx_empty and evt_tx_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Drop the frame in progress and return to idle |
| cfg_pad_en | input | 1 | Zero-pad short frames to 60 bytes |
| cfg_crc_auto | input | 1 | Checksum is appended downstream; no slot is expected from the writer |
| wr_valid | input | 1 | Write word present |
| wr_data | input | 32 | Write word |
| wr_busy | output | 1 | Writes held off while a frame streams out |
| m_data | output | 8 | Output frame byte |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Final byte of the frame |
| m_ready | input | 1 | Downstream accepts the byte |
| evt_tx_empty | output | 1 | One-cycle pulse after a frame is fully sent |
| evt_tx_err | output | 1 | One-cycle pulse on a rejected length |

## Verification
The bench aims at the length limits: 2032 must be accepted and 2033 rejected. An off-by-one in the limit would either send a frame that is too long or refuse a legal one. It also covers zero-length frames and short frames with and without padding. A design that counted the checksum slot wrongly would cut off real payload or leak slot bytes, and one that padded from the stored count would emit stale bytes instead of zeros. Write words are pushed while the previous frame is still streaming, so a design that consumed them under busy would corrupt or lose the next header. Aborts are issued both in mid-fill and in mid-stream, where a faulty design would resume stale data or emit a spurious completion pulse.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } txf_state_e;

  localparam int LANES = 4;
  localparam int LANE_W = 8;
endpackage

// File: rtl/txf_len_calc.sv
module txf_len_calc #(
  parameter int MAX_PAYLOAD = 2032,
  parameter int HDR_BYTES   = 14,
  parameter int FCS_BYTES   = 4,
  parameter int MIN_FRAME   = 60,
  parameter int CNTW        = 12
) (
  input  logic [15:0]     hdr_len,
  input  logic            crc_auto,
  output logic            too_long,
  output logic [CNTW-1:0] exp_cnt,
  input  logic [CNTW-1:0] fin_exp,
  input  logic            fin_strip,
  input  logic            fin_pad,
  output logic [CNTW-1:0] fin_data_len,
  output logic [CNTW-1:0] fin_send_len
);
  logic [16:0] sum;

  always_comb begin
    too_long = (hdr_len > 16'(MAX_PAYLOAD));
    sum      = {1'b0, hdr_len} + 17'(HDR_BYTES) + (crc_auto ? 17'd0 : 17'(FCS_BYTES));
    exp_cnt  = CNTW'(sum);
  end

  always_comb begin
    fin_data_len = fin_strip ? (fin_exp - CNTW'(FCS_BYTES)) : fin_exp;
    if (fin_pad && (fin_data_len < CNTW'(MIN_FRAME)))
      fin_send_len = CNTW'(MIN_FRAME);
    else
      fin_send_len = fin_data_len;
  end
endmodule

// File: rtl/txf_byte_ram.sv
module txf_byte_ram #(
  parameter int DEPTH = 513,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txf_assembler.sv
module txf_assembler #(
  parameter int MAX_PAYLOAD = 2032,
  parameter int HDR_BYTES   = 14,
  parameter int FCS_BYTES   = 4,
  parameter int MIN_FRAME   = 60
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        cfg_pad_en,
  input  logic        cfg_crc_auto,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_busy,
  output logic [7:0]  m_data,
  output logic        m_valid,
  output logic        m_last,
  input  logic        m_ready,
  output logic        evt_tx_empty,
  output logic        evt_tx_err
);
  import txf_pkg::*;

  localparam int MAX_FRAME = MAX_PAYLOAD + HDR_BYTES + FCS_BYTES;
  localparam int CNTW      = $clog2(MAX_FRAME + 8);
  localparam int AW        = CNTW - 2;
  localparam int WORDS     = (MAX_FRAME + 2 + 3) / LANES;

  txf_state_e      state;
  logic [CNTW-1:0] cnt_q, exp_q, idx_q, data_len_q, send_len_q;
  logic [AW-1:0]   wptr_q;
  logic            strip_q, err_q, empty_q, zero_q;
  logic [1:0]      lane_q;

  logic            accept, too_long, fill_done, fire;
  logic [CNTW-1:0] exp_cnt, cnt_n, fin_data_len, fin_send_len;
  logic [CNTW-1:0] idx_nxt, rd_j, data_len_d;
  logic [AW-1:0]   waddr, raddr;
  logic [LANE_W-1:0] rd_lane [LANES];

  assign accept  = wr_valid && (state != ST_SEND) && !abort;
  assign fire    = m_valid && m_ready;
  assign cnt_n   = cnt_q + CNTW'(LANES);
  assign fill_done = accept && (state == ST_FILL) && (cnt_n >= exp_q);

  txf_len_calc #(
    .MAX_PAYLOAD(MAX_PAYLOAD), .HDR_BYTES(HDR_BYTES), .FCS_BYTES(FCS_BYTES),
    .MIN_FRAME(MIN_FRAME), .CNTW(CNTW)
  ) u_len (
    .hdr_len     (wr_data[15:0]),
    .crc_auto    (cfg_crc_auto),
    .too_long    (too_long),
    .exp_cnt     (exp_cnt),
    .fin_exp     (exp_q),
    .fin_strip   (strip_q),
    .fin_pad     (cfg_pad_en),
    .fin_data_len(fin_data_len),
    .fin_send_len(fin_send_len)
  );

  // Byte j of the lane store holds frame byte j-2; header bytes sit in lanes 2 and 3 of word 0.
  assign waddr = (state == ST_IDLE) ? '0 : wptr_q;

  always_comb begin
    idx_nxt = idx_q;
    if (state == ST_SEND && fire) idx_nxt = idx_q + 1'b1;
    if (state != ST_SEND) idx_nxt = '0;
    rd_j       = idx_nxt + CNTW'(2);
    raddr      = rd_j[CNTW-1:2];
    data_len_d = fill_done ? fin_data_len : data_len_q;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic lane_we;
    assign lane_we = accept &&
                     (((state == ST_IDLE) && !too_long && (b >= 2)) || (state == ST_FILL));
    txf_byte_ram #(.DEPTH(WORDS), .AW(AW), .DW(LANE_W)) u_ram (
      .clk  (clk),
      .we   (lane_we),
      .waddr(waddr),
      .wdata(wr_data[LANE_W*b +: LANE_W]),
      .raddr(raddr),
      .rdata(rd_lane[b])
    );
  end

  always_ff @(posedge clk) begin
    lane_q <= rd_j[1:0];
    zero_q <= (idx_nxt >= data_len_d);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state      <= ST_IDLE;
      cnt_q      <= '0;
      exp_q      <= '0;
      idx_q      <= '0;
      wptr_q     <= '0;
      strip_q    <= 1'b0;
      data_len_q <= '0;
      send_len_q <= '0;
      err_q      <= 1'b0;
      empty_q    <= 1'b0;
    end else begin
      err_q   <= 1'b0;
      empty_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (too_long) begin
              err_q <= 1'b1;
            end else begin
              exp_q   <= exp_cnt;
              strip_q <= !cfg_crc_auto;
              cnt_q   <= CNTW'(2);
              wptr_q  <= AW'(1);
              state   <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (accept) begin
            cnt_q  <= cnt_n;
            wptr_q <= wptr_q + 1'b1;
            if (fill_done) begin
              data_len_q <= fin_data_len;
              send_len_q <= fin_send_len;
              idx_q      <= '0;
              state      <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (m_last) begin
              state   <= ST_IDLE;
              idx_q   <= '0;
              empty_q <= 1'b1;
            end else begin
              idx_q <= idx_nxt;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign m_valid      = (state == ST_SEND);
  assign m_last       = m_valid && (idx_q == send_len_q - 1'b1);
  assign m_data       = zero_q ? '0 : rd_lane[lane_q];
  assign wr_busy      = (state == ST_SEND);
  assign evt_tx_empty = empty_q;
  assign evt_tx_err   = err_q;
endmodule

// File: rtl/txf_assembler_chk.sv
module txf_assembler_chk #(
  parameter int MIN_FRAME = 60,
  parameter int MAX_SENT  = 2046
) (
  input logic       clk,
  input logic       rst,
  input logic       abort,
  input logic       cfg_pad_en,
  input logic       wr_busy,
  input logic [7:0] m_data,
  input logic       m_valid,
  input logic       m_last,
  input logic       m_ready,
  input logic       evt_tx_empty,
  input logic       evt_tx_err
);
  int fcnt;

  always_ff @(posedge clk) begin
    if (rst || abort) fcnt <= 0;
    else if (m_valid && m_ready) fcnt <= m_last ? 0 : fcnt + 1;
  end

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!m_valid && !wr_busy && !evt_tx_empty && !evt_tx_err));

  p_reject_idle_r2: assert property (@(posedge clk) disable iff (rst)
    evt_tx_err |-> (!m_valid && !evt_tx_empty));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst || abort)
    (m_valid && m_ready && m_last) |=> (evt_tx_empty && !m_valid));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    evt_tx_empty |=> !evt_tx_empty);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst || abort)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!m_valid && !wr_busy && !evt_tx_empty));

  p_pad_min_r6: assert property (@(posedge clk) disable iff (rst || abort)
    (m_valid && m_ready && m_last && cfg_pad_en) |-> (fcnt + 1 >= MIN_FRAME));

  p_len_max_r5: assert property (@(posedge clk) disable iff (rst || abort)
    (m_valid && m_ready) |-> (fcnt + 1 <= MAX_SENT));
endmodule

bind txf_assembler txf_assembler_chk #(
  .MIN_FRAME(MIN_FRAME),
  .MAX_SENT (MAX_PAYLOAD + HDR_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .cfg_pad_en(cfg_pad_en),
  .wr_busy(wr_busy), .m_data(m_data), .m_valid(m_valid), .m_last(m_last),
  .m_ready(m_ready), .evt_tx_empty(evt_tx_empty), .evt_tx_err(evt_tx_err)
);

// File: tb/txf_assembler_tb.sv
module txf_assembler_tb;
  localparam int CLK_PERIOD = 10;

  typedef logic [7:0]  bq_t[$];
  typedef logic [31:0] wq_t[$];

  logic clk = 1'b0, rst = 1'b1, abort = 1'b0;
  logic cfg_pad_en = 1'b0, cfg_crc_auto = 1'b1;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_busy, m_valid, m_last, evt_tx_empty, evt_tx_err;
  logic [7:0] m_data;
  logic m_ready = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txf_assembler u_dut (
    .clk(clk), .rst(rst), .abort(abort), .cfg_pad_en(cfg_pad_en),
    .cfg_crc_auto(cfg_crc_auto), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_busy(wr_busy), .m_data(m_data), .m_valid(m_valid), .m_last(m_last),
    .m_ready(m_ready), .evt_tx_empty(evt_tx_empty), .evt_tx_err(evt_tx_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int words_needed(input int len, input bit crc_auto);
    int e = len + 14 + (crc_auto ? 0 : 4);
    return (e - 2 + 3) / 4;
  endfunction

  function automatic bq_t model(input logic [31:0] hdr, input wq_t w,
                                input bit crc_auto, input bit pad);
    bq_t q;
    int e = int'(hdr[15:0]) + 14 + (crc_auto ? 0 : 4);
    int s;
    q.push_back(hdr[23:16]);
    q.push_back(hdr[31:24]);
    foreach (w[i]) for (int b = 0; b < 4; b++) q.push_back(w[i][8*b +: 8]);
    s = crc_auto ? e : e - 4;
    while (q.size() > s) void'(q.pop_back());
    if (pad) while (q.size() < 60) q.push_back(8'h00);
    return q;
  endfunction

  task automatic build(input int len, input bit crc_auto,
                       output logic [31:0] hdr, output wq_t w);
    hdr = {$urandom_range(0, 65535) & 32'hFFFF, 16'(len)} ;
    hdr = {hdr[15:0], 16'(len)};
    w = {};
    for (int i = 0; i < words_needed(len, crc_auto); i++) w.push_back($urandom);
  endtask

  // Entered and left at a falling edge.
  task automatic wr(input logic [31:0] w);
    bit acc;
    wr_valid = 1'b1;
    wr_data  = w;
    do begin
      acc = !wr_busy;
      @(negedge clk);
    end while (!acc);
    wr_valid = 1'b0;
  endtask

  task automatic collect(input bq_t exp, input string req, input int pct);
    int  got = 0, guard = 0;
    bit  done = 0, stall = 0, r;
    logic [7:0] pd = '0;
    logic       pl = 1'b0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (stall) chk(m_valid && m_data == pd && m_last == pl, "R10", "hold under stall",
                     int'(m_data), int'(pd));
      r = ($urandom % 100) < pct;
      m_ready = r;
      if (m_valid) begin
        if (r) begin
          if (got < exp.size())
            chk(m_data == exp[got], req, $sformatf("byte %0d", got), int'(m_data), int'(exp[got]));
          chk(m_last == (got == exp.size() - 1), req, "last flag", int'(m_last),
              int'(got == exp.size() - 1));
          got++;
          if (m_last) done = 1;
        end
        stall = !r; pd = m_data; pl = m_last;
      end else stall = 0;
    end
    @(negedge clk);
    m_ready = 1'b0;
    chk(got == exp.size(), "R5", "frame length", got, exp.size());
    chk(evt_tx_empty == 1'b1, "R7", "empty pulse", int'(evt_tx_empty), 1);
    chk(!m_valid && !wr_busy, "R7", "idle after frame", int'(m_valid), 0);
    @(negedge clk);
    chk(evt_tx_empty == 1'b0, "R7", "empty pulse width", int'(evt_tx_empty), 0);
  endtask

  task automatic run_frame(input int len, input bit crc_auto, input bit pad,
                           input string req, input int pct);
    logic [31:0] hdr;
    wq_t w;
    bq_t exp;
    cfg_crc_auto = crc_auto;
    cfg_pad_en   = pad;
    build(len, crc_auto, hdr, w);
    exp = model(hdr, w, crc_auto, pad);
    wr(hdr);
    foreach (w[i]) wr(w[i]);
    collect(exp, req, pct);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [31:0] hdr_a, hdr_b;
    wq_t wa, wb;
    bq_t ea, eb;
    void'($urandom(32'h1F2E3D4C));

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(!m_valid && !wr_busy && !evt_tx_empty && !evt_tx_err, "R11", "outputs in reset",
        int'(m_valid | wr_busy | evt_tx_empty | evt_tx_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!m_valid && !wr_busy && !evt_tx_empty && !evt_tx_err, "R11", "outputs after reset",
        int'(m_valid | wr_busy | evt_tx_empty | evt_tx_err), 0);

    // R1 R3 R4: header bytes and word order
    run_frame(46, 1'b1, 1'b0, "R1", 100);
    run_frame(46, 1'b1, 1'b0, "R4", 40);
    // R5: checksum slot stripped
    run_frame(46, 1'b0, 1'b0, "R5", 70);
    run_frame(3, 1'b0, 1'b0, "R3", 70);
    // R6: padding, zero-length and short frames
    run_frame(0, 1'b1, 1'b1, "R6", 60);
    run_frame(0, 1'b1, 1'b0, "R3", 60);
    run_frame(10, 1'b0, 1'b1, "R6", 50);
    run_frame(45, 1'b1, 1'b1, "R6", 80);
    run_frame(100, 1'b0, 1'b1, "R6", 80);

    // R2: rejected length, then a legal frame
    cfg_crc_auto = 1'b1; cfg_pad_en = 1'b0;
    wr({16'hBEEF, 16'd2033});
    chk(evt_tx_err == 1'b1, "R2", "error pulse", int'(evt_tx_err), 1);
    chk(!m_valid && !wr_busy, "R2", "idle after reject", int'(m_valid | wr_busy), 0);
    @(negedge clk);
    chk(evt_tx_err == 1'b0, "R2", "error pulse width", int'(evt_tx_err), 0);
    wr({16'h1234, 16'hFFFF});
    chk(evt_tx_err == 1'b1, "R2", "error on max field", int'(evt_tx_err), 1);
    run_frame(5, 1'b1, 1'b0, "R2", 90);

    // R3 R5: the largest legal length
    run_frame(2032, 1'b1, 1'b0, "R3", 100);
    run_frame(2032, 1'b0, 1'b0, "R5", 90);

    // R8: next frame written while the previous one streams out
    cfg_crc_auto = 1'b1; cfg_pad_en = 1'b1;
    build(30, 1'b1, hdr_a, wa);
    ea = model(hdr_a, wa, 1'b1, 1'b1);
    build(70, 1'b1, hdr_b, wb);
    eb = model(hdr_b, wb, 1'b1, 1'b1);
    wr(hdr_a);
    foreach (wa[i]) wr(wa[i]);
    fork
      begin
        collect(ea, "R8", 30);
        collect(eb, "R8", 60);
      end
      begin
        chk(wr_busy == 1'b1, "R8", "busy while streaming", int'(wr_busy), 1);
        wr(hdr_b);
        foreach (wb[i]) wr(wb[i]);
      end
    join

    // R9: abort during fill
    cfg_crc_auto = 1'b1; cfg_pad_en = 1'b0;
    wr({16'hAAAA, 16'd40});
    wr(32'h11111111);
    wr(32'h22222222);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!m_valid && !wr_busy, "R9", "idle after fill abort", int'(m_valid | wr_busy), 0);
    run_frame(20, 1'b1, 1'b0, "R9", 80);

    // R9: abort during streaming
    build(100, 1'b1, hdr_a, wa);
    wr(hdr_a);
    foreach (wa[i]) wr(wa[i]);
    m_ready = 1'b1;
    repeat (5) @(negedge clk);
    abort = 1'b1;
    m_ready = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    chk(!m_valid && !wr_busy, "R9", "idle after stream abort", int'(m_valid | wr_busy), 0);
    chk(!evt_tx_empty, "R9", "no empty pulse on abort", int'(evt_tx_empty), 0);
    @(negedge clk);
    chk(!evt_tx_empty && !m_valid, "R9", "still quiet", int'(evt_tx_empty | m_valid), 0);
    run_frame(12, 1'b0, 1'b1, "R9", 80);

    // Constrained random frames
    for (int k = 0; k < 24; k++) begin
      int len = (k % 6 == 0) ? $urandom_range(1500, 2032) : $urandom_range(0, 200);
      run_frame(len, 1'($urandom % 2), 1'($urandom % 2), "R5",
                $urandom_range(25, 100));
    end

    finish_run();
  end
endmodule